// File: doc/BRIEF.md
# Logarithmic Multiplexer Barrel Shifter

This block is a purely combinational word shifter. It takes a data word, a shift distance and a two-bit mode, and returns the shifted word in the same cycle with no clock and no stored state. The supported modes are logical left, logical right, arithmetic right and rotate right. The rotate mode can be left out at build time.

The shift passes through a chain of multiplexer rows, one row for each bit of the distance. The row driven by distance bit k moves the word by either zero or 2^k places. The bit that enters a vacated position is chosen by a small decoder. It is zero for logical modes, a copy of the sign bit for arithmetic right, and the bit that falls off the other end for rotate. Left shifts use the same right-shifting rows: the word is mirrored before the rows and mirrored again after them.

The caller chooses the distance beforehand, either from an instruction's immediate field or from a register operand. The block only sees the final value.

Top module: `barrel_shifter`

## Requirements
- R1: Mode 2'b00 (logical left) returns dataIn shifted toward the MSB by shiftAmt places, with zeros entering at the LSB end.
- R2: Mode 2'b01 (logical right) returns dataIn shifted toward the LSB by shiftAmt places, with zeros entering at the MSB end.
- R3: Mode 2'b10 (arithmetic right) shifts toward the LSB, and every vacated upper position takes the original dataIn MSB.
- R4: When ROTATE_EN=1, mode 2'b11 rotates right: bits leaving the LSB end re-enter at the MSB end, and no bit is lost.
- R5: When ROTATE_EN=0, mode 2'b11 behaves exactly like mode 2'b01 (logical right).
- R6: A shiftAmt of 0 returns dataIn unchanged in every mode.
- R7: Every distance from 0 to DATA_W-1 is honoured, including the largest one. At distance 31, logical left leaves only the old LSB in the MSB, and arithmetic right yields a word made entirely of the sign bit.
- R8: The output depends only on the present inputs and settles within the cycle in which they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | DATA_W (32) | Word to be shifted |
| shiftAmt | input | AMT_W (5) | Shift distance, 0 to DATA_W-1 |
| shiftMode | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| dataOut | output | DATA_W (32) | Shifted word |

## Verification
The bench builds two copies at DATA_W=32. One has ROTATE_EN=1 and the other has ROTATE_EN=0. The same stimulus therefore exercises both the wrap-around connections and the fall-back of mode 11 to a logical right shift. Driving each single-bit distance (1, 2, 4, 8, 16) isolates one multiplexer row at a time. Distances 0 and 31, combined with patterns whose MSB is set and clear, reach the fill and sign-copy corners in every mode.

// File: rtl/barrel_shifter_pkg.sv
package barrel_shifter_pkg;

  typedef enum logic [1:0] {
    MODE_SLL  = 2'b00,
    MODE_SRL  = 2'b01,
    MODE_SRA  = 2'b10,
    MODE_ROTR = 2'b11
  } shiftMode_e;

  // Strobes from the decoder to the shift network
  typedef struct packed {
    logic mirror;   // reverse word before and after the right-shift rows
    logic arith;    // vacated bits take the original sign
    logic wrap;     // vacated bits take the bits that fall out
  } shiftCtrl_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import barrel_shifter_pkg::*;
#(
  parameter bit ROTATE_EN = 1'b1
) (
  input  logic [1:0]  shiftMode,
  output shiftCtrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (shiftMode)
      MODE_SLL:  ctrl.mirror = 1'b1;
      MODE_SRL:  ;
      MODE_SRA:  ctrl.arith  = 1'b1;
      MODE_ROTR: ctrl.wrap   = ROTATE_EN;
      default:   ;
    endcase
  end

  // R5: the wrap strobe exists only in builds that include rotate.
  always_comb begin
    if (!$isunknown(shiftMode)) begin
      p_no_wrap_r5: assert (ROTATE_EN || !ctrl.wrap)
        else $error("wrap strobe set with rotate disabled");
      p_strobe_excl_r8: assert ($onehot0(ctrl))
        else $error("more than one strobe active");
    end
  end

endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int DATA_W = 32,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] stageIn,
  input  logic              stageEn,
  input  logic              fillBit,
  input  logic              wrapEn,
  output logic [DATA_W-1:0] stageOut
);

  logic [DATA_W-1:0] moved;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i + DIST < DATA_W) begin : g_inside
      assign moved[i] = stageIn[i + DIST];
    end else begin : g_edge
      assign moved[i] = wrapEn ? stageIn[i + DIST - DATA_W] : fillBit;
    end
  end

  assign stageOut = stageEn ? moved : stageIn;

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import barrel_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  shiftCtrl_t        ctrl,
  output logic [DATA_W-1:0] dataOut
);

  localparam int STAGES = AMT_W;

  logic [DATA_W-1:0] mirrorIn;
  logic [DATA_W-1:0] netOut;
  logic [DATA_W-1:0] mirrorOut;
  logic [DATA_W-1:0] chain [STAGES+1];
  logic              fillBit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign mirrorIn[i]  = dataIn[DATA_W-1-i];
    assign mirrorOut[i] = netOut[DATA_W-1-i];
  end

  assign fillBit  = ctrl.arith & dataIn[DATA_W-1];
  assign chain[0] = ctrl.mirror ? mirrorIn : dataIn;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    shift_stage #(
      .DATA_W (DATA_W),
      .DIST   (1 << k)
    ) u_stage (
      .stageIn  (chain[k]),
      .stageEn  (shiftAmt[k]),
      .fillBit  (fillBit),
      .wrapEn   (ctrl.wrap),
      .stageOut (chain[k+1])
    );
  end

  assign netOut  = chain[STAGES];
  assign dataOut = ctrl.mirror ? mirrorOut : netOut;

  always_comb begin
    if (!$isunknown({dataIn, shiftAmt, ctrl})) begin
      p_zero_pass_r6: assert (shiftAmt != '0 || dataOut == dataIn)
        else $error("zero distance altered the word");
      p_sign_keep_r3: assert (!ctrl.arith || dataOut[DATA_W-1] == dataIn[DATA_W-1])
        else $error("arithmetic shift lost the sign");
      p_wrap_count_r4: assert (!ctrl.wrap || $countones(dataOut) == $countones(dataIn))
        else $error("rotate changed the number of ones");
      p_left_fill_r1: assert (!ctrl.mirror || shiftAmt == '0 || !dataOut[0])
        else $error("left shift filled LSB with one");
      p_right_fill_r2: assert (ctrl.mirror || ctrl.arith || ctrl.wrap ||
                               shiftAmt == '0 || !dataOut[DATA_W-1])
        else $error("logical right shift filled MSB with one");
    end
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_shifter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit ROTATE_EN = 1'b1,
  parameter int AMT_W     = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [1:0]        shiftMode,
  output logic [DATA_W-1:0] dataOut
);

  shiftCtrl_t ctrl;

  shift_ctrl #(
    .ROTATE_EN (ROTATE_EN)
  ) u_ctrl (
    .shiftMode (shiftMode),
    .ctrl      (ctrl)
  );

  shift_datapath #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_dp (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .ctrl     (ctrl),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/barrel_shifter_tb.sv
module barrel_shifter_tb;

  logic        clk = 1'b0;
  logic [31:0] dataIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  shiftMode = '0;
  logic [31:0] dataOut;
  logic [31:0] dataOutNoRot;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  barrel_shifter #(.DATA_W(32), .ROTATE_EN(1'b1)) u_dut (
    .dataIn(dataIn), .shiftAmt(shiftAmt), .shiftMode(shiftMode), .dataOut(dataOut));

  barrel_shifter #(.DATA_W(32), .ROTATE_EN(1'b0)) u_dut_norot (
    .dataIn(dataIn), .shiftAmt(shiftAmt), .shiftMode(shiftMode), .dataOut(dataOutNoRot));

  function automatic logic [31:0] model(input logic [31:0] a, input int n,
                                        input logic [1:0] m, input bit rot);
    case (m)
      2'b00: return a << n;
      2'b01: return a >> n;
      2'b10: return 32'($signed(a) >>> n);
      default: begin
        if (!rot) return a >> n;
        if (n == 0) return a;
        return (a >> n) | (a << (32 - n));
      end
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input int n, input logic [1:0] m);
    @(posedge clk);
    dataIn = a; shiftAmt = 5'(n); shiftMode = m;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: in=%h amt=%0d mode=%0d actual=%h expected=%h",
               req, dataIn, shiftAmt, shiftMode, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] a, input int n, input logic [1:0] m);
    apply(a, n, m);
    check(req, dataOut, model(a, n, m, 1'b1));
    check(req, dataOutNoRot, model(a, n, m, 1'b0));
  endtask

  task automatic t_initial_r8();
    @(negedge clk);
    check("R8 initial", dataOut, 32'h0);
  endtask

  task automatic t_left_r1();
    run("R1", 32'h8000_0001, 1, 2'b00);
    run("R1", 32'hDEAD_BEEF, 4, 2'b00);
    run("R1", 32'h1234_5678, 13, 2'b00);
  endtask

  task automatic t_right_r2();
    run("R2", 32'hF000_000F, 1, 2'b01);
    run("R2", 32'hDEAD_BEEF, 8, 2'b01);
    run("R2", 32'hFFFF_FFFF, 19, 2'b01);
  endtask

  task automatic t_arith_r3();
    run("R3", 32'h8000_0000, 3, 2'b10);
    run("R3", 32'h7FFF_FFFF, 5, 2'b10);
    run("R3", 32'hC0DE_1234, 17, 2'b10);
  endtask

  task automatic t_rotate_r4_r5();
    run("R4 R5", 32'h0000_0001, 1, 2'b11);
    run("R4 R5", 32'h8765_4321, 12, 2'b11);
    run("R4 R5", 32'hA5A5_0F0F, 27, 2'b11);
  endtask

  task automatic t_zero_r6();
    for (int m = 0; m < 4; m++) run("R6", 32'hCAFE_F00D, 0, 2'(m));
  endtask

  task automatic t_stages_r7();
    for (int k = 0; k < 5; k++)
      for (int m = 0; m < 4; m++) run("R7", 32'h9ABC_DEF1, 1 << k, 2'(m));
    apply(32'h0000_0001, 31, 2'b00);
    check("R7 sll31", dataOut, 32'h8000_0000);
    apply(32'h8000_0000, 31, 2'b10);
    check("R7 sra31", dataOut, 32'hFFFF_FFFF);
    for (int m = 0; m < 4; m++) run("R7", 32'h8000_0001, 31, 2'(m));
  endtask

  initial begin
    t_initial_r8();
    t_left_r1();
    t_right_r2();
    t_arith_r3();
    t_rotate_r4_r5();
    t_zero_r6();
    t_stages_r7();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule